// File: doc/BRIEF.md
# Latched Parity Bus Transceiver

This block joins two byte-wide buses, called side A and side B, each carrying its own parity bit. Either side can be the source of a transfer. The word sent to the other side carries the source data unchanged. Its parity bit is either copied from the source or computed afresh from the source data. Each side has a latch on its incoming word. A latch is either transparent or holding a captured word, and a held word is what both the parity generator and the checker then see. Both sides are checked for parity at all times, and the two results are reported on separate active-low flags.

The shared bus pins are split into an input word, an output word and a drive-enable per side, so the block fits inside a synchronous chip. The latches are modelled as clock-sampled registers with a load enable. A latch's output follows its input at once while its enable is high. When the enable is low, the latch returns the word sampled at the last rising clock edge at which the enable was high. When a side is being driven, its latch takes the driven word instead of its input pins. The checker on that side therefore checks the outgoing word, and it can capture that word.

Direction is decoded from the two active-low enables into four named transfer states: `XFER_IDLE` (neither side driven), `XFER_A2B` (side B driven from side A), `XFER_B2A` (side A driven from side B) and `XFER_CLASH` (both enables active). The decode has no transitions of its own: it follows the enable pins in the same cycle. In `XFER_CLASH` neither side is driven and a clash flag is raised.

Top module: `lpx_transceiver`

## Requirements
- R1: After reset, both held latch words are zero. With both latch enables low, both drive enables low and even parity selected, both error flags read 1, the clash flag reads 0 and all output words read zero.
- R2: Direction is decoded from {a_oe_n, b_oe_n} in the same cycle: 2'b11 gives no drive, 2'b10 drives side B (b_drive=1), and 2'b01 drives side A (a_drive=1). A side that is not driven shows all-zero data and parity outputs.
- R3: With ft_sel=0 (generate mode), the driven parity bit makes the total count of ones across the 8 data bits and the parity bit even when odd_sel=0 and odd when odd_sel=1.
- R4: With ft_sel=1 (feed-through mode), the driven parity bit equals the parity bit at the source latch output.
- R5: The driven data bits equal the data bits at the source latch output, in both modes.
- R6: With its enable high, a latch passes its input word through in the same cycle. With its enable low, it returns the word it sampled at the last rising clock edge at which the enable was high, and the held word does not change.
- R7: Each error flag is 0 exactly when the count of ones over that side's latch output (8 data bits plus parity bit, parity at bit 0 of the word) disagrees with the sense chosen by odd_sel (even for 0, odd for 1). Otherwise the flag is 1.
- R8: Parity checking stays active in feed-through mode. A bad source parity sets the source-side flag to 0, and also the destination-side flag when the destination latch is transparent.
- R9: The latch of the driven side takes the driven word instead of its input pins. Its flag checks that word while the latch is transparent, and the latch keeps that word once its enable falls.
- R10: When both a_oe_n and b_oe_n are 0, neither side is driven, both output words are zero and dir_clash reads 1. In every other state dir_clash reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that samples the latch registers |
| rst_n | input | 1 | Active-low reset, clears both held words |
| a_data_i | input | 8 | Data seen on the side A bus pins |
| a_par_i | input | 1 | Parity bit seen on the side A pins |
| b_data_i | input | 8 | Data seen on the side B bus pins |
| b_par_i | input | 1 | Parity bit seen on the side B pins |
| a_oe_n | input | 1 | Active-low request to drive side A |
| b_oe_n | input | 1 | Active-low request to drive side B |
| ft_sel | input | 1 | 1 selects feed-through parity, 0 selects generated parity |
| odd_sel | input | 1 | 1 selects odd parity, 0 selects even parity |
| a_le | input | 1 | Side A latch enable, high is transparent |
| b_le | input | 1 | Side B latch enable, high is transparent |
| a_data_o | output | 8 | Data driven toward side A |
| a_par_o | output | 1 | Parity bit driven toward side A |
| a_drive | output | 1 | Side A output enable |
| b_data_o | output | 8 | Data driven toward side B |
| b_par_o | output | 1 | Parity bit driven toward side B |
| b_drive | output | 1 | Side B output enable |
| a_err_n | output | 1 | Side A parity error flag, active low |
| b_err_n | output | 1 | Side B parity error flag, active low |
| dir_clash | output | 1 | Both drive requests active at once |

## Verification
The bench builds the block with its default width of 8 data bits, which matches the bus this block serves. At that width the bench can step through all 64 combinations of direction, parity mode, parity sense and the two latch enables, with random and deliberately corrupted parity in each combination. Directed scenarios then pin down exact parity values for chosen bytes. They also cover a held word surviving later changes on its pins, and a generated word being captured by the far-side latch and sent back the other way.

// File: rtl/lpx_pkg.sv
package lpx_pkg;

    // Transfer states decoded from the two active-low drive requests.
    typedef enum logic [1:0] {
        XFER_IDLE  = 2'd0,
        XFER_A2B   = 2'd1,
        XFER_B2A   = 2'd2,
        XFER_CLASH = 2'd3
    } xfer_e;

endpackage

// File: rtl/lpx_dir_decode.sv
module lpx_dir_decode
    import lpx_pkg::*;
(
    input  logic  a_oe_n_i,
    input  logic  b_oe_n_i,
    output xfer_e xfer_o,
    output logic  drive_a_o,
    output logic  drive_b_o,
    output logic  clash_o
);

    // State decode from the request pins.
    always_comb begin
        unique case ({a_oe_n_i, b_oe_n_i})
            2'b11:   xfer_o = XFER_IDLE;
            2'b10:   xfer_o = XFER_A2B;
            2'b01:   xfer_o = XFER_B2A;
            default: xfer_o = XFER_CLASH;
        endcase
    end

    // Output decode per state.
    always_comb begin
        drive_a_o = 1'b0;
        drive_b_o = 1'b0;
        clash_o   = 1'b0;
        unique case (xfer_o)
            XFER_IDLE:  ;
            XFER_A2B:   drive_b_o = 1'b1;
            XFER_B2A:   drive_a_o = 1'b1;
            XFER_CLASH: clash_o   = 1'b1;
        endcase
    end

endmodule

// File: rtl/lpx_parity_unit.sv
module lpx_parity_unit #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] data_i,
    input  logic          odd_i,
    output logic          gen_o
);

    // Bit that brings the total ones count to the selected sense.
    assign gen_o = (^data_i) ^ odd_i;

endmodule

// File: rtl/lpx_side_latch.sv
module lpx_side_latch #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         le_i,
    input  logic         fb_sel_i,
    input  logic [W-1:0] d_pin_i,
    input  logic [W-1:0] d_fb_i,
    output logic [W-1:0] q_o,
    output logic [W-1:0] q_pin_o
);

    logic [W-1:0] held_q;
    logic [W-1:0] d_sel;

    assign d_sel   = fb_sel_i ? d_fb_i : d_pin_i;
    assign q_o     = le_i ? d_sel : held_q;
    // Pin-only view, valid whenever this side is not being driven.
    assign q_pin_o = le_i ? d_pin_i : held_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= '0;
        end else begin
            held_q <= q_o;
        end
    end

    assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !le_i |=> $stable(held_q));

endmodule

// File: rtl/lpx_transceiver.sv
module lpx_transceiver
    import lpx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] a_data_i,
    input  logic              a_par_i,
    input  logic [DATA_W-1:0] b_data_i,
    input  logic              b_par_i,
    input  logic              a_oe_n,
    input  logic              b_oe_n,
    input  logic              ft_sel,
    input  logic              odd_sel,
    input  logic              a_le,
    input  logic              b_le,
    output logic [DATA_W-1:0] a_data_o,
    output logic              a_par_o,
    output logic              a_drive,
    output logic [DATA_W-1:0] b_data_o,
    output logic              b_par_o,
    output logic              b_drive,
    output logic              a_err_n,
    output logic              b_err_n,
    output logic              dir_clash
);

    localparam int WORD_W = DATA_W + 1;
    localparam int SIDES  = 2;

    xfer_e                         xfer;
    logic [SIDES-1:0][WORD_W-1:0]  pin_w;
    logic [SIDES-1:0][WORD_W-1:0]  q_w;
    logic [SIDES-1:0][WORD_W-1:0]  qpin_w;
    logic [SIDES-1:0][WORD_W-1:0]  drv_w;
    logic [SIDES-1:0]              le_v;
    logic [SIDES-1:0]              drv_en;
    logic [SIDES-1:0]              ok_v;

    // Word layout: data in the upper bits, parity at bit 0. Index 0 is side A.
    assign pin_w[0] = {a_data_i, a_par_i};
    assign pin_w[1] = {b_data_i, b_par_i};
    assign le_v     = {b_le, a_le};

    lpx_dir_decode u_dec (
        .a_oe_n_i  (a_oe_n),
        .b_oe_n_i  (b_oe_n),
        .xfer_o    (xfer),
        .drive_a_o (drv_en[0]),
        .drive_b_o (drv_en[1]),
        .clash_o   (dir_clash)
    );

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        localparam int FAR = SIDES - 1 - s;
        logic out_gen;
        logic chk_gen;

        lpx_side_latch #(.W(WORD_W)) u_lat (
            .clk      (clk),
            .rst_n    (rst_n),
            .le_i     (le_v[s]),
            .fb_sel_i (drv_en[s]),
            .d_pin_i  (pin_w[s]),
            .d_fb_i   (drv_w[s]),
            .q_o      (q_w[s]),
            .q_pin_o  (qpin_w[s])
        );

        // Generator for the word sent toward this side from the far latch.
        lpx_parity_unit #(.DW(DATA_W)) u_gen (
            .data_i (qpin_w[FAR][WORD_W-1:1]),
            .odd_i  (odd_sel),
            .gen_o  (out_gen)
        );

        // Checker on this side's own latch output.
        lpx_parity_unit #(.DW(DATA_W)) u_chk (
            .data_i (q_w[s][WORD_W-1:1]),
            .odd_i  (odd_sel),
            .gen_o  (chk_gen)
        );

        assign drv_w[s] = drv_en[s]
                        ? {qpin_w[FAR][WORD_W-1:1], (ft_sel ? qpin_w[FAR][0] : out_gen)}
                        : '0;
        assign ok_v[s]  = (chk_gen == q_w[s][0]);
    end

    assign {a_data_o, a_par_o} = drv_w[0];
    assign {b_data_o, b_par_o} = drv_w[1];
    assign a_drive = drv_en[0];
    assign b_drive = drv_en[1];
    assign a_err_n = ok_v[0];
    assign b_err_n = ok_v[1];

    // ---------------- assertions ----------------
    assert_one_driver_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({a_drive, b_drive}));

    assert_clash_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dir_clash |-> (!a_drive && !b_drive && a_data_o == '0 && b_data_o == '0));

    assert_gen_parity_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (b_drive && !ft_sel) |-> ((^{b_data_o, b_par_o}) == odd_sel));

    assert_gen_parity_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (a_drive && !ft_sel) |-> ((^{a_data_o, a_par_o}) == odd_sel));

    assert_feed_through_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (a_le && b_drive && ft_sel) |-> ({b_data_o, b_par_o} == {a_data_i, a_par_i}));

    assert_pin_check_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (a_le && !a_drive) |-> (a_err_n == ((^{a_data_i, a_par_i}) == odd_sel)));

    assert_feedback_check_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (b_le && b_drive) |-> (b_err_n == ((^{b_data_o, b_par_o}) == odd_sel)));

endmodule

// File: tb/lpx_transceiver_tb.sv
module lpx_transceiver_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] a_data_i = '0, b_data_i = '0;
    logic       a_par_i = 1'b0, b_par_i = 1'b0;
    logic       a_oe_n = 1'b1, b_oe_n = 1'b1;
    logic       ft_sel = 1'b0, odd_sel = 1'b0, a_le = 1'b0, b_le = 1'b0;
    logic [7:0] a_data_o, b_data_o;
    logic       a_par_o, b_par_o, a_drive, b_drive, a_err_n, b_err_n, dir_clash;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    // Bench-side model state.
    logic [8:0] m_a_held = '0, m_b_held = '0;
    logic [8:0] m_a_eff, m_b_eff;

    always #5 clk = ~clk;

    lpx_transceiver u_dut (
        .clk(clk), .rst_n(rst_n),
        .a_data_i(a_data_i), .a_par_i(a_par_i), .b_data_i(b_data_i), .b_par_i(b_par_i),
        .a_oe_n(a_oe_n), .b_oe_n(b_oe_n), .ft_sel(ft_sel), .odd_sel(odd_sel),
        .a_le(a_le), .b_le(b_le),
        .a_data_o(a_data_o), .a_par_o(a_par_o), .a_drive(a_drive),
        .b_data_o(b_data_o), .b_par_o(b_par_o), .b_drive(b_drive),
        .a_err_n(a_err_n), .b_err_n(b_err_n), .dir_clash(dir_clash)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Apply inputs after a falling edge, then compare against the model.
    task automatic drive(input string tag, input logic [7:0] ad, input logic ap,
                         input logic [7:0] bd, input logic bp,
                         input logic aoe, input logic boe, input logic ft,
                         input logic odd, input logic ale, input logic ble);
        logic       a2b, b2a;
        logic [8:0] a_src, b_src, e_a_out, e_b_out;
        @(negedge clk);
        a_data_i = ad; a_par_i = ap; b_data_i = bd; b_par_i = bp;
        a_oe_n = aoe; b_oe_n = boe; ft_sel = ft; odd_sel = odd; a_le = ale; b_le = ble;
        #1;
        a2b   = aoe & ~boe;
        b2a   = ~aoe & boe;
        a_src = ale ? {ad, ap} : m_a_held;
        b_src = ble ? {bd, bp} : m_b_held;
        e_b_out = a2b ? {a_src[8:1], (ft ? a_src[0] : ((^a_src[8:1]) ^ odd))} : 9'd0;
        e_a_out = b2a ? {b_src[8:1], (ft ? b_src[0] : ((^b_src[8:1]) ^ odd))} : 9'd0;
        m_a_eff = ale ? (b2a ? e_a_out : {ad, ap}) : m_a_held;
        m_b_eff = ble ? (a2b ? e_b_out : {bd, bp}) : m_b_held;
        check({tag, " ctl"}, {11'd0, a_drive, b_drive, dir_clash, a_err_n, b_err_n},
              {11'd0, b2a, a2b, (~aoe & ~boe), ((^m_a_eff) == odd), ((^m_b_eff) == odd)});
        check({tag, " a_out"}, {7'd0, a_data_o, a_par_o}, {7'd0, e_a_out});
        check({tag, " b_out"}, {7'd0, b_data_o, b_par_o}, {7'd0, e_b_out});
    endtask

    task automatic tick();
        @(posedge clk);
        m_a_held = m_a_eff;
        m_b_held = m_b_eff;
    endtask

    task automatic test_reset();
        @(negedge clk);
        #1;
        check("R1 reset ctl", {11'd0, a_drive, b_drive, dir_clash, a_err_n, b_err_n}, 16'h0003);
        check("R1 reset words", {b_data_o, a_data_o}, 16'h0000);
    endtask

    task automatic test_direction();
        drive("R2 idle", 8'h11, 1'b0, 8'h22, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
        check("R2 idle words", {b_data_o, a_data_o}, 16'h0000);
        tick();
        drive("R2 a2b", 8'h11, 1'b0, 8'h22, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        check("R2 a2b drive", {14'd0, a_drive, b_drive}, 16'h0001);
        tick();
        drive("R2 b2a", 8'h11, 1'b0, 8'h22, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
        check("R2 b2a drive", {14'd0, a_drive, b_drive}, 16'h0002);
        tick();
        drive("R10 clash", 8'h11, 1'b0, 8'h22, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        check("R10 clash flag", {13'd0, a_drive, b_drive, dir_clash}, 16'h0001);
        tick();
    endtask

    task automatic test_generate();
        drive("R3 gen even", 8'hA5, 1'b1, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        check("R3 A5 even par", {15'd0, b_par_o}, 16'd0);
        check("R5 data copy", {8'd0, b_data_o}, 16'h00A5);
        tick();
        drive("R3 gen odd", 8'hA5, 1'b1, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        check("R3 A5 odd par", {15'd0, b_par_o}, 16'd1);
        tick();
        drive("R3 gen b2a", 8'h00, 1'b0, 8'h07, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        check("R3 07 even par", {7'd0, a_data_o, a_par_o}, {7'd0, 8'h07, 1'b1});
        tick();
    endtask

    task automatic test_feedthrough();
        drive("R4 ft", 8'hA5, 1'b1, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
        check("R4 par copied", {15'd0, b_par_o}, 16'd1);
        check("R8 both flags low", {14'd0, a_err_n, b_err_n}, 16'd0);
        tick();
    endtask

    task automatic test_hold();
        drive("R6 load", 8'h3C, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        tick();
        drive("R6 held", 8'hFF, 1'b1, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R6 held data", {8'd0, b_data_o}, 16'h003C);
        check("R7 held check", {15'd0, a_err_n}, 16'd1);
        tick();
        drive("R6 still held", 8'h01, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R6 held twice", {8'd0, b_data_o}, 16'h003C);
        tick();
    endtask

    task automatic test_feedback();
        drive("R9 a2b", 8'h81, 1'b1, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        check("R9 far flag ok", {15'd0, b_err_n}, 16'd1);
        check("R9 gen par", {15'd0, b_par_o}, 16'd0);
        tick();
        drive("R9 return", 8'h00, 1'b0, 8'h55, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        check("R9 captured word", {7'd0, a_data_o, a_par_o}, {7'd0, 8'h81, 1'b0});
        tick();
    endtask

    task automatic test_sweep();
        for (int c = 0; c < 64; c++) begin
            for (int k = 0; k < 3; k++) begin
                logic [7:0] ad, bd;
                logic [1:0] ds;
                ad = 8'($urandom);
                bd = 8'($urandom);
                ds = c[1:0];
                drive("R5 R7 R8 sweep", ad, (^ad) ^ c[3] ^ (k == 1), bd, (^bd) ^ c[3] ^ (k == 2),
                      ~ds[1], ~ds[0], c[2], c[3], c[4], c[5]);
                tick();
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_direction();
        test_generate();
        test_feedthrough();
        test_hold();
        test_feedback();
        test_sweep();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule